// File: doc/BRIEF.md
# Synchronous Burst Read Controller for 16-bit NOR Memory

This block serves host read requests by running synchronous burst reads on a 16-bit NOR-style memory. A host offers a byte address, a width flag (16 or 32 bits) and a transfer count while `req_ready` is high. The controller then opens an address phase, lets a programmed latency go by and collects halfword beats under the memory's wait signal. It returns one response word per host transfer. It derives the memory clock from the system clock and holds that clock off during the first system cycle of every address phase, so that the first rising edge lands inside the address-valid pulse. When a burst would step over a programmable page boundary, the controller closes it and opens a fresh address phase at the next halfword.

The controller is built around a six-state machine. The states are IDLE, SETUP, ADDR, LATENCY, BEATS and GAP. IDLE moves to SETUP when a request is accepted. SETUP lasts one system cycle, with the clock held low, and then moves to ADDR. ADDR moves to LATENCY at the end of its memory clock period, or straight to BEATS when the latency is zero. LATENCY moves to BEATS on the rising edge that completes the latency count. BEATS moves to GAP after the final beat, or after a beat that ends a page. GAP moves back to SETUP while beats remain, and otherwise to IDLE.

Top module: `nor_burst_rd`

## Requirements
- R1: After reset and whenever idle, `mem_clk` is low, `mem_cs_n` and `mem_adv_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: In the first system cycle of every address phase, `mem_cs_n` and `mem_adv_n` are low and `mem_clk` is still low. The first rising edge of `mem_clk` comes while `mem_adv_n` has already been low for at least one cycle. `mem_adv_n` rises again at the end of that memory clock period.
- R3: The memory clock period is `cfg_div` system cycles. `mem_clk` is high from phase `cfg_div/2` (rounded down) to the end of the period. Values below 2 act as 2, and values above 16 act as 16.
- R4: After the address edge, `cfg_lat` rising edges pass without sampling. Data is sampled only on rising edges after those.
- R5: `mem_wait` has no effect during the latency edges. After the latency, a rising edge with `mem_wait` high accepts no beat, and the beat count holds.
- R6: A request carries `req_len` + 1 host transfers. It takes that many beats when `req_wide` is 0 and twice as many when it is 1. Beats read consecutive halfword addresses starting at `req_addr >> 1`, and `mem_addr` carries the halfword address of the current burst's first beat.
- R7: A 16-bit transfer returns `{16'h0, beat}`. A 32-bit transfer returns `{second beat, first beat}`, so the lower address lands in bits 15:0. There is one `rsp_valid` pulse per host transfer.
- R8: `mem_cs_n` is high in the cycle after the final beat is captured, and `req_ready` comes back after that.
- R9: `cfg_page` selects the page size: 1 is 128 bytes, 2 is 256, 3 is 512 and 4 is 1024. Any other value means no split. A burst never carries a beat whose halfword address is a page start, unless that beat is the burst's first. The next beat opens a new address phase instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 5 | Memory clock divide ratio (clamped to 2..16) |
| cfg_lat | input | 4 | Latency in memory clock edges after the address edge |
| cfg_page | input | 3 | Page size select for burst splitting |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_addr | input | 24 | Byte address of the first transfer |
| req_wide | input | 1 | 1 = 32-bit transfers, 0 = 16-bit transfers |
| req_len | input | 4 | Number of host transfers minus one |
| rsp_valid | output | 1 | One-cycle pulse per returned word |
| rsp_data | output | 32 | Returned word |
| mem_clk | output | 1 | Divided memory clock |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | 23 | Halfword address of the current burst |
| mem_rdata | input | 16 | Memory read data |
| mem_wait | input | 1 | Memory wait, high = data not ready |

## Verification
Two functions can land on the same rising edge: the page-boundary split and the end of the whole transfer. Both are due when the last requested halfword is also the last halfword of a page. Directed requests that end exactly on a page end, or that start two halfwords before one, provoke this case. The bench judges it by counting address phases against a count computed from the addresses, and by checking that chip select rises right after the final beat with no extra phase. Random wait pulses also fall on those boundary beats, which tests whether the split and the release hold off correctly until the beat is really accepted.

// File: rtl/nor_burst_pkg.sv
package nor_burst_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ADDR,
        S_LATENCY,
        S_BEATS,
        S_GAP
    } nbr_state_t;

    // Page size in halfwords for a page select code; 0 means no split.
    function automatic int unsigned page_halfwords(input logic [2:0] sel);
        unique case (sel)
            3'd1:    return 64;
            3'd2:    return 128;
            3'd3:    return 256;
            3'd4:    return 512;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/nbr_clkgen.sv
module nbr_clkgen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mem_clk,
    output logic             rise,
    output logic             period_end
);
    logic [DIV_W-1:0] ph;
    logic [DIV_W-1:0] half;

    assign half       = div >> 1;
    assign mem_clk    = run && (ph >= half);
    assign rise       = run && (ph == half);
    assign period_end = run && (ph == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ph <= '0;
        else if (!run)       ph <= '0;
        else if (period_end) ph <= '0;
        else                 ph <= ph + 1'b1;
    end

    assert_phase_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph < div));

endmodule

// File: rtl/nbr_assemble.sv
module nbr_assemble #(
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide,
    input  logic          capture,
    input  logic [MW-1:0] beat,
    output logic          rsp_valid,
    output logic [2*MW-1:0] rsp_data
);
    logic          upper;
    logic [MW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper     <= 1'b0;
            low_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (start) begin
                upper <= 1'b0;
            end else if (capture) begin
                if (wide && !upper) begin
                    low_q <= beat;
                    upper <= 1'b1;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= wide ? {beat, low_q} : {{MW{1'b0}}, beat};
                    upper     <= 1'b0;
                end
            end
        end
    end

    assert_no_back_to_back_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wide) |=> !rsp_valid);

endmodule

// File: rtl/nor_burst_rd.sv
module nor_burst_rd
    import nor_burst_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int MW      = 16,
    parameter int LEN_W   = 4,
    parameter int LAT_W   = 4,
    parameter int DIV_W   = 5,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LAT_W-1:0]  cfg_lat,
    input  logic [2:0]        cfg_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wide,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [2*MW-1:0]   rsp_data,
    output logic              mem_clk,
    output logic              mem_cs_n,
    output logic              mem_adv_n,
    output logic [ADDR_W-2:0] mem_addr,
    input  logic [MW-1:0]     mem_rdata,
    input  logic              mem_wait
);
    localparam int HW_AW  = ADDR_W - 1;
    localparam int BEAT_W = LEN_W + 2;

    nbr_state_t state, state_nx;

    logic [BEAT_W-1:0] beats_left;
    logic [LAT_W-1:0]  lat_cnt, lat_q;
    logic [DIV_W-1:0]  div_q, div_c;
    logic [2:0]        page_q;
    logic              wide_q;
    logic [HW_AW-1:0]  cur_addr, seg_addr, nxt_addr, pg_mask;
    logic              page_on, boundary;
    logic              run, rise, period_end, capture, accept;
    logic [BEAT_W-1:0] beats_init;

    // Inputs and derived values
    assign accept     = req_valid && (state == S_IDLE);
    assign div_c      = (cfg_div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) :
                        (cfg_div > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : cfg_div;
    assign beats_init = (BEAT_W'(req_len) + BEAT_W'(1)) << req_wide;
    assign page_on    = (page_halfwords(page_q) != 0);
    assign pg_mask    = HW_AW'(page_halfwords(page_q) - 1);
    assign nxt_addr   = cur_addr + 1'b1;
    assign boundary   = page_on && ((nxt_addr & pg_mask) == '0);
    assign capture    = (state == S_BEATS) && rise && !mem_wait;

    nbr_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .div        (div_q),
        .mem_clk    (mem_clk),
        .rise       (rise),
        .period_end (period_end)
    );

    nbr_assemble #(.MW(MW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .wide      (wide_q),
        .capture   (capture),
        .beat      (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_SETUP;
            S_SETUP:   state_nx = S_ADDR;
            S_ADDR:    if (period_end) state_nx = (lat_q == '0) ? S_BEATS : S_LATENCY;
            S_LATENCY: if (rise && (lat_cnt == lat_q - 1'b1)) state_nx = S_BEATS;
            S_BEATS:   if (capture && ((beats_left == BEAT_W'(1)) || boundary)) state_nx = S_GAP;
            S_GAP:     state_nx = (beats_left == '0) ? S_IDLE : S_SETUP;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_cs_n  = 1'b1;
        mem_adv_n = 1'b1;
        run       = 1'b0;
        unique case (state)
            S_IDLE:    req_ready = 1'b1;
            S_SETUP:   begin mem_cs_n = 1'b0; mem_adv_n = 1'b0; end
            S_ADDR:    begin mem_cs_n = 1'b0; mem_adv_n = 1'b0; run = 1'b1; end
            S_LATENCY: begin mem_cs_n = 1'b0; run = 1'b1; end
            S_BEATS:   begin mem_cs_n = 1'b0; run = 1'b1; end
            S_GAP:     ;
            default:   ;
        endcase
    end
    assign mem_addr = seg_addr;

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_left <= '0;
            lat_cnt    <= '0;
            lat_q      <= '0;
            div_q      <= DIV_W'(DIV_MIN);
            page_q     <= '0;
            wide_q     <= 1'b0;
            cur_addr   <= '0;
            seg_addr   <= '0;
        end else begin
            if (accept) begin
                beats_left <= beats_init;
                lat_q      <= cfg_lat;
                div_q      <= div_c;
                page_q     <= cfg_page;
                wide_q     <= req_wide;
                cur_addr   <= req_addr[ADDR_W-1:1];
                seg_addr   <= req_addr[ADDR_W-1:1];
            end
            if (state == S_ADDR) lat_cnt <= '0;
            else if (state == S_LATENCY && rise) lat_cnt <= lat_cnt + 1'b1;
            if (capture) begin
                cur_addr   <= nxt_addr;
                beats_left <= beats_left - 1'b1;
            end
            if (state == S_GAP && beats_left != '0) seg_addr <= cur_addr;
        end
    end

    // Checks next to the logic they guard
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_clk && mem_cs_n && mem_adv_n));

    assert_first_cycle_clock_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (!mem_clk && !mem_adv_n));

    assert_rise_inside_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !mem_adv_n) |-> $past(!mem_adv_n));

    assert_wait_holds_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BEATS) && rise && mem_wait) |=> $stable(beats_left));

    assert_no_sample_in_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LATENCY) |=> $stable(cur_addr));

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && beats_left == BEAT_W'(1)) |=> mem_cs_n);

    assert_page_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && beats_left > BEAT_W'(1) && boundary) |=> (mem_cs_n && mem_adv_n));

endmodule

// File: tb/sim_nor_burst_rd.sv
module sim_nor_burst_rd;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cfg_div;
    logic [3:0]  cfg_lat;
    logic [2:0]  cfg_page;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_addr;
    logic        req_wide;
    logic [3:0]  req_len;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_clk, mem_cs_n, mem_adv_n;
    logic [22:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_wait;

    always #4 clk = ~clk;  // 125 MHz

    nor_burst_rd u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_lat(cfg_lat),
        .cfg_page(cfg_page), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wide(req_wide), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_clk(mem_clk),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wait(mem_wait)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] memval(input logic [22:0] a);
        return (a[15:0] * 16'h2F1B) ^ 16'hC3A5 ^ {9'd0, a[22:16]};
    endfunction

    function automatic int clamp_div(input int d);
        return (d < 2) ? 2 : (d > 16) ? 16 : d;
    endfunction

    function automatic int page_hw(input int sel);
        return (sel >= 1 && sel <= 4) ? (32 << sel) : 0;
    endfunction

    function automatic int exp_phases(input logic [22:0] start, input int beats, input int sel);
        int n = 1;
        int pg = page_hw(sel);
        for (int k = 1; k < beats; k++) begin
            logic [22:0] a = start + 23'(k);
            if (pg != 0 && (a & 23'(pg - 1)) == 0) n++;
        end
        return n;
    endfunction

    // Memory model and observation state
    logic [31:0] exp_w [16];
    int          exp_n, rsp_cnt;
    logic [22:0] b_next, seg_start;
    int          b_total, b_deliv, b_lat, b_div, b_pg, rcount, phases, last_rise;
    bit          prev_clk, prev_cs, prev_adv, chk_cs, active;

    always @(negedge clk) begin
        bit rise_now;
        cyc++;
        rise_now = mem_clk && !prev_clk;
        mem_wait  = ($urandom % 2) == 0;
        mem_rdata = 16'hDEAD;
        if (chk_cs) begin
            check(mem_cs_n == 1'b1, "R8", "chip select after final beat", mem_cs_n, 1);
            chk_cs = 0;
        end
        if (active) begin
            if (!mem_cs_n && prev_cs) begin
                check(!mem_clk && !mem_adv_n, "R2", "first cycle clock held / adv low",
                      {mem_clk, mem_adv_n}, 0);
            end
            if (rise_now && !mem_adv_n) begin
                phases++;
                check(prev_adv == 1'b0, "R2", "adv low before first rise", prev_adv, 0);
                check(mem_addr == b_next, "R6", "address phase address", mem_addr, b_next);
                seg_start = b_next;
                rcount    = 0;
                last_rise = cyc;
            end else if (rise_now && !mem_cs_n) begin
                rcount++;
                check(cyc - last_rise == b_div, "R3", "memory clock period",
                      cyc - last_rise, b_div);
                last_rise = cyc;
                if (rcount > b_lat) begin
                    if (($urandom % 4) == 0) begin
                        mem_wait = 1'b1;
                    end else begin
                        mem_wait  = 1'b0;
                        mem_rdata = memval(b_next);
                        if (b_pg != 0 && b_next != seg_start &&
                            (b_next & 23'(b_pg - 1)) == 0)
                            check(0, "R9", "beat crosses page", b_next, seg_start);
                        b_next++;
                        b_deliv++;
                        if (b_deliv == b_total) chk_cs = 1;
                    end
                end
            end
        end
        if (rsp_valid) begin
            if (rsp_cnt < exp_n)
                check(rsp_data == exp_w[rsp_cnt], "R7", "response word", rsp_data,
                      exp_w[rsp_cnt]);
            else
                check(0, "R6", "extra response", rsp_cnt, exp_n);
            rsp_cnt++;
        end
        prev_clk = mem_clk;
        prev_cs  = mem_cs_n;
        prev_adv = mem_adv_n;
    end

    task automatic run_tx(input logic [23:0] addr, input bit wide, input int len,
                          input int div, input int lat, input int pg);
        int n;
        logic [22:0] hw;
        @(negedge clk);
        cfg_div  = 5'(div);
        cfg_lat  = 4'(lat);
        cfg_page = 3'(pg);
        req_addr = addr;
        req_wide = wide;
        req_len  = 4'(len);
        hw       = addr[23:1];
        exp_n    = len + 1;
        for (int i = 0; i < exp_n; i++) begin
            if (wide)
                exp_w[i] = {memval(hw + 23'(2*i + 1)), memval(hw + 23'(2*i))};
            else
                exp_w[i] = {16'h0, memval(hw + 23'(i))};
        end
        rsp_cnt  = 0;
        b_next   = hw;
        b_total  = exp_n * (wide ? 2 : 1);
        b_deliv  = 0;
        b_lat    = lat;
        b_div    = clamp_div(div);
        b_pg     = page_hw(pg);
        phases   = 0;
        active   = 1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!(rsp_cnt >= exp_n && req_ready) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n < 20000, "R6", "transaction completes", n, 0);
        check(rsp_cnt == exp_n, "R6", "response count", rsp_cnt, exp_n);
        check(b_deliv == b_total, "R6", "beats taken", b_deliv, b_total);
        check(phases == exp_phases(hw, b_total, pg), "R9", "address phases", phases,
              exp_phases(hw, b_total, pg));
        check(mem_cs_n && mem_adv_n && !mem_clk, "R1", "idle pins after transfer",
              {mem_cs_n, mem_adv_n, mem_clk}, 3'b110);
        active = 0;
    endtask

    initial begin
        int guard = 0;
        while (guard < 150000) begin
            @(posedge clk);
            guard++;
        end
        check(0, "R1", "watchdog expired", guard, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wide = 1'b0; req_len = '0;
        cfg_div = 5'd2; cfg_lat = '0; cfg_page = '0; mem_wait = 1'b0; mem_rdata = '0;
        active = 0; chk_cs = 0; prev_clk = 0; prev_cs = 1; prev_adv = 1;
        exp_n = 0; rsp_cnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_clk && mem_cs_n && mem_adv_n && req_ready && !rsp_valid, "R1",
              "reset state", {mem_clk, mem_cs_n, mem_adv_n, req_ready, rsp_valid}, 5'b01110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corners
        run_tx(24'h000100, 1'b0, 0, 2, 0, 0);   // R4 zero latency, R6 single 16-bit
        run_tx(24'h000200, 1'b1, 0, 3, 2, 0);   // R6 32-bit single is two beats
        run_tx(24'h000078, 1'b1, 1, 4, 1, 1);   // R9 ends exactly at page end: one phase
        run_tx(24'h00007C, 1'b1, 2, 2, 3, 1);   // R9 split two beats in
        run_tx(24'h0003F8, 1'b0, 9, 5, 2, 3);   // R9 512-byte page split, 16-bit
        run_tx(24'h000400, 1'b1, 3, 0, 1, 2);   // R3 divide below range acts as 2
        run_tx(24'h000500, 1'b0, 2, 31, 1, 7);  // R3 divide above range acts as 16
        run_tx(24'h0007F0, 1'b1, 15, 6, 5, 4);  // R5/R9 long burst over 1024-byte page

        // Constrained random
        for (int t = 0; t < 40; t++) begin
            logic [23:0] a;
            a = {11'(($urandom % 64) + 1), 7'h0, 6'h0} - 24'(($urandom % 8) * 4);
            a = a >> 6;
            a[1:0] = 2'b00;
            run_tx(a, 1'($urandom % 2), int'($urandom % 6), int'($urandom % 7) + 2,
                   int'($urandom % 6), int'($urandom % 8));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule